// File: doc/BRIEF.md
# MAC Address Table with Insert Engine

This block holds a small table of station-address entries and a sequential engine that places a unicast or multicast MAC address into it. Software-side logic reaches the table through a narrow register port. A table-index register selects an entry. Three data words stage an entry's contents. Writing the index register with its top bit set stores the staged words at that entry. Writing it with the top bit clear copies the entry into the data words. The same port holds global control bits: table enable, table clear and VLAN-aware mode. It also holds a 2-bit forwarding state for each port.

An insert request carries a MAC address, a unicast/multicast kind, and either a port number with secure and blocked flags (unicast) or a port mask (multicast). The engine sweeps every entry once and keeps the first hit of three kinds. After the sweep it writes the entry into the slot chosen by a fixed priority: an entry already holding the same address, else the lowest free entry, else the lowest ageable unicast entry. A multicast insert that lands on an existing entry merges its port mask into the stored one. When no slot qualifies, nothing is written and a table-full flag is raised. While a sweep runs the engine reports busy, and register accesses wait.

Top module: `mac_tbl_insert`

## Requirements
- R1: After reset every entry is free (all zero), all control bits and port states read 0, `reg_ready` is 1 and `ins_busy` is 0.
- R2: Register map by word address: 0 control, 1 table index, 2 entry bits 64 and up (zero-extended), 3 entry bits 63:32, 4 entry bits 31:0, 5+p state of port p. A write to address 1 with bit 31 set stores the three data words at the index in the low bits. Without bit 31 it loads that entry into the data words. Address 1 reads back the last index written.
- R3: Control bit 31 is table enable and bit 2 is VLAN-aware; both read back and drive `tbl_enable` and `tbl_vlan_aware`. Writing bit 30 as 1 zeroes every entry, and bit 30 always reads 0.
- R4: Each port state is 2 bits (0 disable, 1 block, 2 learn, 3 forward), reads back at its address, and appears on `port_state[2p+1:2p]`.
- R5: A unicast insert writes entry type 1 in bits 61:60, the MAC in bits 47:0 (first byte in 47:40), 0 (persistent) in bits 63:62, secure in bit 64, blocked in bit 65, the port number in bits 67:66, and zero elsewhere.
- R6: An entry of type 1 or 3 whose bits 47:0 equal the inserted MAC is chosen, even when a free entry has a lower index.
- R7: With no address match, the lowest-index entry of type 0 is chosen.
- R8: With no match and no free entry, the lowest-index entry of type 1 or 3 is chosen that has bit 40 clear and bits 63:62 equal to 1 or 3. Entries with bits 63:62 of 0 or 2, and entries with bit 40 set, are never chosen this way.
- R9: A multicast insert writes type 1, MAC in bits 47:0 and forward state 3 in bits 63:62. The port mask sits at bits 66 and up and is the OR of the new mask and the mask already stored at a matched entry (zero otherwise).
- R10: When no entry qualifies, `ins_done` comes with `ins_full` high and the table is left unchanged.
- R11: An accepted insert raises `ins_busy` from the next cycle. `ins_done` is a one-cycle pulse, DEPTH cycles after the first busy cycle. Busy drops after it. While busy, `reg_ready` is 0 and register accesses take no effect until it returns to 1.
- R12: An insert request while the enable bit is 0 is ignored: no busy, no done, no table change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_req | input | 1 | Register access request, held until `reg_ready` |
| reg_we | input | 1 | 1 write, 0 read |
| reg_addr | input | AW | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_ready | output | 1 | Access accepted this cycle when high |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| ins_req | input | 1 | Insert request |
| ins_mcast | input | 1 | 1 multicast insert, 0 unicast |
| ins_mac | input | 48 | Address to insert |
| ins_port | input | 2 | Unicast port number |
| ins_mask | input | PORTS | Multicast port mask |
| ins_secure | input | 1 | Unicast secure flag |
| ins_blocked | input | 1 | Unicast blocked flag |
| ins_busy | output | 1 | Sweep in progress |
| ins_done | output | 1 | One-cycle completion pulse |
| ins_full | output | 1 | With `ins_done`: no slot found |
| ins_index | output | IDX_W | With `ins_done`: chosen entry |
| tbl_enable | output | 1 | Table enable bit |
| tbl_vlan_aware | output | 1 | VLAN-aware mode bit |
| port_state | output | 2*PORTS | Per-port forwarding state |

## Verification
The bench builds the block with DEPTH of 4 and PORTS of 3. Four entries can be filled by hand in a few register writes, so the ageable pass and the table-full outcome are both reachable in a short directed run. The sweep latency is short enough to count exactly. Three ports make the entry 69 bits, which exercises the mask bit that spills past bit 67 and the five-bit top data word.

// File: rtl/mat_pkg.sv
package mat_pkg;

   // entry type codes, bits 61:60
   localparam logic [1:0] ETYPE_FREE      = 2'd0;
   localparam logic [1:0] ETYPE_ADDR      = 2'd1;
   localparam logic [1:0] ETYPE_VLAN      = 2'd2;
   localparam logic [1:0] ETYPE_VLAN_ADDR = 2'd3;

   // unicast kind / multicast state, bits 63:62
   localparam logic [1:0] UKIND_PERSIST   = 2'd0;
   localparam logic [1:0] UKIND_UNTOUCHED = 2'd1;
   localparam logic [1:0] UKIND_OUI       = 2'd2;
   localparam logic [1:0] UKIND_TOUCHED   = 2'd3;
   localparam logic [1:0] MSTATE_FWD      = 2'd3;

   // register word addresses
   localparam int RA_CTRL  = 0;
   localparam int RA_INDEX = 1;
   localparam int RA_WHI   = 2;
   localparam int RA_WMID  = 3;
   localparam int RA_WLO   = 4;
   localparam int RA_PORT0 = 5;

   typedef enum logic [1:0] {
      SC_IDLE   = 2'd0,
      SC_SWEEP  = 2'd1,
      SC_COMMIT = 2'd2
   } scan_state_t;

   function automatic logic holds_addr(input logic [1:0] etype);
      return (etype == ETYPE_ADDR) || (etype == ETYPE_VLAN_ADDR);
   endfunction

   function automatic logic is_reclaimable(input logic [1:0] etype,
                                           input logic       grp_bit,
                                           input logic [1:0] ukind);
      return holds_addr(etype) && !grp_bit &&
             ((ukind == UKIND_UNTOUCHED) || (ukind == UKIND_TOUCHED));
   endfunction

endpackage

// File: rtl/mat_store.sv
module mat_store #(
   parameter int DEPTH   = 16,
   parameter int IDX_W   = 4,
   parameter int ENTRY_W = 69
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_idx,
   input  logic [ENTRY_W-1:0] wr_entry,
   input  logic [IDX_W-1:0]   a_idx,
   output logic [ENTRY_W-1:0] a_entry,
   input  logic [IDX_W-1:0]   b_idx,
   output logic [ENTRY_W-1:0] b_entry
);

   logic [DEPTH-1:0][ENTRY_W-1:0] flat;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [ENTRY_W-1:0] ent_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            ent_q <= '0;
         else if (clr)
            ent_q <= '0;
         else if (wr_en && (wr_idx == IDX_W'(i)))
            ent_q <= wr_entry;
      end
      assign flat[i] = ent_q;
   end

   assign a_entry = flat[a_idx];
   assign b_entry = flat[b_idx];

endmodule

// File: rtl/mat_scan.sv
module mat_scan
   import mat_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int PORTS   = 3,
   parameter int IDX_W   = 4,
   parameter int ENTRY_W = 69
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               mcast,
   input  logic [47:0]        mac,
   input  logic [1:0]         port,
   input  logic [PORTS-1:0]   mask,
   input  logic               secure,
   input  logic               blocked,
   output logic [IDX_W-1:0]   rd_idx,
   input  logic [ENTRY_W-1:0] rd_entry,
   output logic               wr_en,
   output logic [IDX_W-1:0]   wr_idx,
   output logic [ENTRY_W-1:0] wr_entry,
   output logic               busy,
   output logic               done,
   output logic               full,
   output logic [IDX_W-1:0]   index
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   scan_state_t        state;
   logic [IDX_W-1:0]   idx;
   logic               r_mcast, r_sec, r_blk;
   logic [47:0]        r_mac;
   logic [1:0]         r_port;
   logic [PORTS-1:0]   r_mask;

   logic               m_hit, f_hit, a_hit;
   logic [IDX_W-1:0]   m_idx, f_idx, a_idx;
   logic [ENTRY_W-1:0] m_ent;

   logic               now_match, now_free, now_age;
   logic               any_hit;
   logic [IDX_W-1:0]   pick;
   logic [ENTRY_W-1:0] base, build;

   // classify the entry under the sweep pointer
   always_comb begin
      now_match = holds_addr(rd_entry[61:60]) && (rd_entry[47:0] == r_mac);
      now_free  = (rd_entry[61:60] == ETYPE_FREE);
      now_age   = is_reclaimable(rd_entry[61:60], rd_entry[40], rd_entry[63:62]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SC_IDLE;
         idx     <= '0;
         r_mcast <= 1'b0;
         r_sec   <= 1'b0;
         r_blk   <= 1'b0;
         r_mac   <= '0;
         r_port  <= '0;
         r_mask  <= '0;
         m_hit   <= 1'b0;
         f_hit   <= 1'b0;
         a_hit   <= 1'b0;
         m_idx   <= '0;
         f_idx   <= '0;
         a_idx   <= '0;
         m_ent   <= '0;
      end else begin
         case (state)
            SC_IDLE: begin
               if (start) begin
                  state   <= SC_SWEEP;
                  idx     <= '0;
                  m_hit   <= 1'b0;
                  f_hit   <= 1'b0;
                  a_hit   <= 1'b0;
                  r_mcast <= mcast;
                  r_mac   <= mac;
                  r_port  <= port;
                  r_mask  <= mask;
                  r_sec   <= secure;
                  r_blk   <= blocked;
               end
            end
            SC_SWEEP: begin
               if (now_match && !m_hit) begin
                  m_hit <= 1'b1;
                  m_idx <= idx;
                  m_ent <= rd_entry;
               end
               if (now_free && !f_hit) begin
                  f_hit <= 1'b1;
                  f_idx <= idx;
               end
               if (now_age && !a_hit) begin
                  a_hit <= 1'b1;
                  a_idx <= idx;
               end
               if (idx == LAST)
                  state <= SC_COMMIT;
               else
                  idx <= idx + 1'b1;
            end
            SC_COMMIT: state <= SC_IDLE;
            default:   state <= SC_IDLE;
         endcase
      end
   end

   // priority: same address, then free, then reclaimable unicast
   always_comb begin
      any_hit = m_hit || f_hit || a_hit;
      if (m_hit)      pick = m_idx;
      else if (f_hit) pick = f_idx;
      else            pick = a_idx;
   end

   always_comb begin
      base  = (r_mcast && m_hit) ? m_ent : '0;
      build = base;
      build[61:60] = ETYPE_ADDR;
      build[47:0]  = r_mac;
      if (r_mcast) begin
         build[63:62]       = MSTATE_FWD;
         build[66 +: PORTS] = base[66 +: PORTS] | r_mask;
      end else begin
         build[63:62] = UKIND_PERSIST;
         build[64]    = r_sec;
         build[65]    = r_blk;
         build[67:66] = r_port;
      end
   end

   assign rd_idx   = idx;
   assign busy     = (state != SC_IDLE);
   assign done     = (state == SC_COMMIT);
   assign full     = done && !any_hit;
   assign wr_en    = done && any_hit;
   assign wr_idx   = pick;
   assign wr_entry = build;
   assign index    = pick;

endmodule

// File: rtl/mac_tbl_insert.sv
module mac_tbl_insert
   import mat_pkg::*;
#(
   parameter  int DEPTH   = 16,
   parameter  int PORTS   = 3,
   parameter  int AW      = 4,
   localparam int IDX_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int ENTRY_W = (66 + PORTS > 68) ? (66 + PORTS) : 68
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_req,
   input  logic               reg_we,
   input  logic [AW-1:0]      reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic               reg_ready,
   output logic [31:0]        reg_rdata,
   input  logic               ins_req,
   input  logic               ins_mcast,
   input  logic [47:0]        ins_mac,
   input  logic [1:0]         ins_port,
   input  logic [PORTS-1:0]   ins_mask,
   input  logic               ins_secure,
   input  logic               ins_blocked,
   output logic               ins_busy,
   output logic               ins_done,
   output logic               ins_full,
   output logic [IDX_W-1:0]   ins_index,
   output logic               tbl_enable,
   output logic               tbl_vlan_aware,
   output logic [2*PORTS-1:0] port_state
);

   localparam int HI_W = ENTRY_W - 64;

   if (PORTS < 2 || PORTS > 4) begin : g_bad_ports
      $error("PORTS must lie in 2..4 for a 2-bit port number field");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end
   if (RA_PORT0 + PORTS > (1 << AW)) begin : g_bad_aw
      $error("AW too narrow for the port state registers");
   end

   logic                    ctrl_en, ctrl_vlan;
   logic [IDX_W-1:0]        sel_idx;
   logic [HI_W-1:0]         d_hi;
   logic [31:0]             d_mid, d_lo;
   logic [PORTS-1:0][1:0]   pstate;

   logic                    acc_wr;
   logic                    clr_pulse, tbl_store, tbl_load;
   logic [IDX_W-1:0]        w_idx;

   logic                    sc_busy, sc_wr_en;
   logic [IDX_W-1:0]        sc_rd_idx, sc_wr_idx;
   logic [ENTRY_W-1:0]      sc_rd_ent, sc_wr_ent, a_ent;

   logic                    st_wr_en;
   logic [IDX_W-1:0]        st_wr_idx;
   logic [ENTRY_W-1:0]      st_wr_ent;

   assign reg_ready = !sc_busy;
   assign acc_wr    = reg_req && reg_we && !sc_busy;
   assign w_idx     = reg_wdata[IDX_W-1:0];
   assign clr_pulse = acc_wr && (reg_addr == AW'(RA_CTRL)) && reg_wdata[30];
   assign tbl_store = acc_wr && (reg_addr == AW'(RA_INDEX)) && reg_wdata[31];
   assign tbl_load  = acc_wr && (reg_addr == AW'(RA_INDEX)) && !reg_wdata[31];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en   <= 1'b0;
         ctrl_vlan <= 1'b0;
         sel_idx   <= '0;
         d_hi      <= '0;
         d_mid     <= '0;
         d_lo      <= '0;
         pstate    <= '0;
      end else if (acc_wr) begin
         if (reg_addr == AW'(RA_CTRL)) begin
            ctrl_en   <= reg_wdata[31];
            ctrl_vlan <= reg_wdata[2];
         end
         if (reg_addr == AW'(RA_INDEX))
            sel_idx <= w_idx;
         if (tbl_load) begin
            d_hi  <= a_ent[ENTRY_W-1:64];
            d_mid <= a_ent[63:32];
            d_lo  <= a_ent[31:0];
         end
         if (reg_addr == AW'(RA_WHI))  d_hi  <= reg_wdata[HI_W-1:0];
         if (reg_addr == AW'(RA_WMID)) d_mid <= reg_wdata;
         if (reg_addr == AW'(RA_WLO))  d_lo  <= reg_wdata;
         for (int p = 0; p < PORTS; p++) begin
            if (reg_addr == AW'(RA_PORT0 + p))
               pstate[p] <= reg_wdata[1:0];
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == AW'(RA_CTRL))
         reg_rdata = {ctrl_en, 1'b0, 27'd0, ctrl_vlan, 2'd0};
      else if (reg_addr == AW'(RA_INDEX))
         reg_rdata[IDX_W-1:0] = sel_idx;
      else if (reg_addr == AW'(RA_WHI))
         reg_rdata[HI_W-1:0] = d_hi;
      else if (reg_addr == AW'(RA_WMID))
         reg_rdata = d_mid;
      else if (reg_addr == AW'(RA_WLO))
         reg_rdata = d_lo;
      else begin
         for (int p = 0; p < PORTS; p++) begin
            if (reg_addr == AW'(RA_PORT0 + p))
               reg_rdata[1:0] = pstate[p];
         end
      end
   end

   // register store and engine commit never coincide: stores need !busy
   assign st_wr_en  = tbl_store || sc_wr_en;
   assign st_wr_idx = tbl_store ? w_idx : sc_wr_idx;
   assign st_wr_ent = tbl_store ? {d_hi, d_mid, d_lo} : sc_wr_ent;

   mat_store #(
      .DEPTH   (DEPTH),
      .IDX_W   (IDX_W),
      .ENTRY_W (ENTRY_W)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr_pulse),
      .wr_en    (st_wr_en),
      .wr_idx   (st_wr_idx),
      .wr_entry (st_wr_ent),
      .a_idx    (w_idx),
      .a_entry  (a_ent),
      .b_idx    (sc_rd_idx),
      .b_entry  (sc_rd_ent)
   );

   mat_scan #(
      .DEPTH   (DEPTH),
      .PORTS   (PORTS),
      .IDX_W   (IDX_W),
      .ENTRY_W (ENTRY_W)
   ) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (ins_req && ctrl_en),
      .mcast    (ins_mcast),
      .mac      (ins_mac),
      .port     (ins_port),
      .mask     (ins_mask),
      .secure   (ins_secure),
      .blocked  (ins_blocked),
      .rd_idx   (sc_rd_idx),
      .rd_entry (sc_rd_ent),
      .wr_en    (sc_wr_en),
      .wr_idx   (sc_wr_idx),
      .wr_entry (sc_wr_ent),
      .busy     (sc_busy),
      .done     (ins_done),
      .full     (ins_full),
      .index    (ins_index)
   );

   assign ins_busy       = sc_busy;
   assign tbl_enable     = ctrl_en;
   assign tbl_vlan_aware = ctrl_vlan;
   assign port_state     = pstate;

endmodule

// File: rtl/mac_tbl_insert_chk.sv
module mac_tbl_insert_chk #(
   parameter int PORTS = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               ins_req,
   input logic               ins_busy,
   input logic               ins_done,
   input logic               ins_full,
   input logic               tbl_enable,
   input logic               tbl_vlan_aware,
   input logic [2*PORTS-1:0] port_state
);

   assert_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && tbl_enable && !ins_busy) |=> ins_busy);

   assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ins_done |=> (!ins_done && !ins_busy));

   assert_done_in_sweep_R11: assert property (@(posedge clk) disable iff (!rst_n)
      ins_done |-> $past(ins_busy));

   assert_hold_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_busy && $past(ins_busy)) |->
         ($stable(port_state) && $stable(tbl_enable) && $stable(tbl_vlan_aware)));

   assert_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (ins_req && !tbl_enable && !ins_busy) |=> !ins_busy);

   assert_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ins_full |-> ins_done);

endmodule

bind mac_tbl_insert mac_tbl_insert_chk #(.PORTS(PORTS)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .ins_req        (ins_req),
   .ins_busy       (ins_busy),
   .ins_done       (ins_done),
   .ins_full       (ins_full),
   .tbl_enable     (tbl_enable),
   .tbl_vlan_aware (tbl_vlan_aware),
   .port_state     (port_state)
);

// File: tb/test_mac_tbl_insert.sv
module test_mac_tbl_insert;

   localparam int DEPTH = 4;
   localparam int PORTS = 3;
   localparam int AW    = 4;
   localparam int IDX_W = 2;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               reg_req = 1'b0, reg_we = 1'b0;
   logic [AW-1:0]      reg_addr = '0;
   logic [31:0]        reg_wdata = '0;
   logic               reg_ready;
   logic [31:0]        reg_rdata;
   logic               ins_req = 1'b0, ins_mcast = 1'b0;
   logic [47:0]        ins_mac = '0;
   logic [1:0]         ins_port = '0;
   logic [PORTS-1:0]   ins_mask = '0;
   logic               ins_secure = 1'b0, ins_blocked = 1'b0;
   logic               ins_busy, ins_done, ins_full;
   logic [IDX_W-1:0]   ins_index;
   logic               tbl_enable, tbl_vlan_aware;
   logic [2*PORTS-1:0] port_state;

   int vectors = 0;
   int miscompares = 0;

   always #10 clk = !clk;

   mac_tbl_insert #(.DEPTH(DEPTH), .PORTS(PORTS), .AW(AW)) i_mac_tbl_insert (
      .clk, .rst_n, .reg_req, .reg_we, .reg_addr, .reg_wdata, .reg_ready, .reg_rdata,
      .ins_req, .ins_mcast, .ins_mac, .ins_port, .ins_mask, .ins_secure, .ins_blocked,
      .ins_busy, .ins_done, .ins_full, .ins_index,
      .tbl_enable, .tbl_vlan_aware, .port_state
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic reg_wr(input int a, input logic [31:0] d);
      @(negedge clk);
      reg_req = 1'b1; reg_we = 1'b1; reg_addr = AW'(a); reg_wdata = d;
      while (!reg_ready) @(negedge clk);
      @(negedge clk);
      reg_req = 1'b0; reg_we = 1'b0;
   endtask

   task automatic reg_rd(input int a, output logic [31:0] d);
      @(negedge clk);
      reg_req = 1'b1; reg_we = 1'b0; reg_addr = AW'(a);
      #1 d = reg_rdata;
      reg_req = 1'b0;
   endtask

   task automatic put_entry(input int idx, input logic [31:0] hi, mid, lo);
      reg_wr(2, hi); reg_wr(3, mid); reg_wr(4, lo);
      reg_wr(1, 32'h8000_0000 | idx);
   endtask

   task automatic expect_entry(input string tag, input int idx,
                               input logic [31:0] hi, mid, lo);
      logic [31:0] v;
      reg_wr(1, idx);
      reg_rd(2, v); check({tag, " hi"}, v, hi);
      reg_rd(3, v); check({tag, " mid"}, v, mid);
      reg_rd(4, v); check({tag, " lo"}, v, lo);
   endtask

   task automatic do_insert(input logic mc, input logic [47:0] mac, input logic [1:0] prt,
                            input logic [2:0] msk, input logic sec, input logic blk,
                            output int idx, output logic fl);
      int cyc;
      logic b0;
      @(negedge clk);
      ins_mcast = mc; ins_mac = mac; ins_port = prt; ins_mask = msk;
      ins_secure = sec; ins_blocked = blk; ins_req = 1'b1;
      @(negedge clk);
      ins_req = 1'b0;
      b0 = ins_busy;
      check("R11 busy after accept", 32'(b0), 32'd1);
      check("R11 ready low while busy", 32'(reg_ready), 32'd0);
      cyc = 0;
      while (!ins_done && cyc < 50) begin
         @(negedge clk);
         cyc++;
      end
      check("R11 done latency", 32'(cyc), 32'(DEPTH));
      idx = int'(ins_index);
      fl  = ins_full;
      @(negedge clk);
      check("R11 idle after done", 32'({ins_busy, ins_done}), 32'd0);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      reg_rd(0, v); check("R1 ctrl", v, 32'd0);
      reg_rd(6, v); check("R1 port1 state", v, 32'd0);
      check("R1 ready/busy", 32'({reg_ready, ins_busy}), 32'h2);
      check("R1 outputs", 32'({tbl_enable, tbl_vlan_aware, port_state}), 32'd0);
      expect_entry("R1 entry2", 2, 32'd0, 32'd0, 32'd0);
   endtask

   task automatic t_access;
      logic [31:0] v;
      put_entry(3, 32'h15, 32'hDEAD_BEEF, 32'h1234_5678);
      reg_wr(2, 32'd0); reg_wr(3, 32'd0); reg_wr(4, 32'd0);
      expect_entry("R2 store/load", 3, 32'h15, 32'hDEAD_BEEF, 32'h1234_5678);
      reg_rd(1, v); check("R2 index readback", v, 32'd3);
      reg_wr(2, 32'hFFFF_FFFF);
      reg_rd(2, v); check("R2 top word width", v, 32'h1F);
   endtask

   task automatic t_control;
      logic [31:0] v;
      reg_wr(0, 32'h8000_0004);
      reg_rd(0, v); check("R3 ctrl readback", v, 32'h8000_0004);
      check("R3 outputs", 32'({tbl_enable, tbl_vlan_aware}), 32'h3);
      reg_wr(0, 32'hC000_0000);
      reg_rd(0, v); check("R3 clear self-clears", v, 32'h8000_0000);
      expect_entry("R3 clear wipes", 3, 32'd0, 32'd0, 32'd0);
   endtask

   task automatic t_ports;
      logic [31:0] v;
      reg_wr(6, 32'd3);
      reg_wr(7, 32'd2);
      reg_rd(6, v); check("R4 port1 readback", v, 32'd3);
      reg_rd(7, v); check("R4 port2 readback", v, 32'd2);
      check("R4 port_state", 32'(port_state), 32'h2C);
   endtask

   task automatic t_disabled;
      logic seen;
      reg_wr(0, 32'h0);
      @(negedge clk);
      ins_mac = 48'h0000_0000_0077; ins_mcast = 1'b0; ins_req = 1'b1;
      @(negedge clk);
      ins_req = 1'b0;
      seen = 1'b0;
      for (int k = 0; k < 8; k++) begin
         if (ins_busy || ins_done) seen = 1'b1;
         @(negedge clk);
      end
      check("R12 ignored while disabled", 32'(seen), 32'd0);
      expect_entry("R12 table untouched", 0, 32'd0, 32'd0, 32'd0);
      reg_wr(0, 32'h8000_0000);
   endtask

   task automatic t_unicast;
      int idx; logic fl;
      do_insert(1'b0, 48'h0011_2233_4455, 2'd2, 3'd0, 1'b1, 1'b0, idx, fl);
      check("R7 first free index", 32'(idx), 32'd0);
      check("R7 not full", 32'(fl), 32'd0);
      expect_entry("R5 unicast layout", 0, 32'h9, 32'h1000_0011, 32'h2233_4455);
   endtask

   task automatic t_match;
      int idx; logic fl;
      do_insert(1'b0, 48'h0200_0000_0010, 2'd0, 3'd0, 1'b0, 1'b0, idx, fl);
      check("R7 next free index", 32'(idx), 32'd1);
      put_entry(0, 32'd0, 32'd0, 32'd0);
      do_insert(1'b0, 48'h0200_0000_0010, 2'd3, 3'd0, 1'b0, 1'b1, idx, fl);
      check("R6 match beats lower free", 32'(idx), 32'd1);
      expect_entry("R6 overwritten", 1, 32'hE, 32'h1000_0200, 32'h0000_0010);
   endtask

   task automatic t_multicast;
      int idx; logic fl;
      do_insert(1'b1, 48'h0100_5E00_0001, 2'd0, 3'b001, 1'b0, 1'b0, idx, fl);
      check("R9 multicast to free", 32'(idx), 32'd0);
      expect_entry("R9 multicast layout", 0, 32'h4, 32'hD000_0100, 32'h5E00_0001);
      do_insert(1'b1, 48'h0100_5E00_0001, 2'd0, 3'b100, 1'b0, 1'b0, idx, fl);
      check("R9 multicast rehit", 32'(idx), 32'd0);
      expect_entry("R9 mask merged", 0, 32'h14, 32'hD000_0100, 32'h5E00_0001);
   endtask

   task automatic t_reclaim_and_full;
      int idx; logic fl;
      put_entry(2, 32'd0, 32'h9000_0000, 32'd2);
      put_entry(3, 32'd0, 32'hD000_0000, 32'd3);
      do_insert(1'b0, 48'h0000_0000_00AA, 2'd1, 3'd0, 1'b0, 1'b0, idx, fl);
      check("R8 reclaim skips group/OUI/persistent", 32'(idx), 32'd3);
      check("R8 not full", 32'(fl), 32'd0);
      expect_entry("R8 reclaimed entry", 3, 32'h4, 32'h1000_0000, 32'h0000_00AA);
      do_insert(1'b0, 48'h0000_0000_00BB, 2'd1, 3'd0, 1'b0, 1'b0, idx, fl);
      check("R10 full flag", 32'(fl), 32'd1);
      expect_entry("R10 entry3 kept", 3, 32'h4, 32'h1000_0000, 32'h0000_00AA);
      expect_entry("R10 entry2 kept", 2, 32'd0, 32'h9000_0000, 32'd2);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_access();
      t_control();
      t_ports();
      t_disabled();
      t_unicast();
      t_match();
      t_multicast();
      t_reclaim_and_full();
      repeat (2) @(negedge clk);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

endmodule